// File: doc/BRIEF.md
# Per-Virtual-Channel Congestion Monitor

This block watches one output port of a switch and judges congestion separately for every virtual channel (VC). Each cycle it folds the VC's current queue occupancy into an exponentially weighted average held with three fractional bits. A VC counts as congested while the integer part of that average is at or above a programmable threshold. Congestion on one VC never changes how another VC is treated.

A packet header leaving the port is presented on the packet inputs. The block returns the header's forward-congestion flag with the bit set if the packet's VC is congested. It raises a drop decision only for a packet that the source flagged as perishable and whose VC queue is completely full. For each marked packet it also asks the surrounding logic to build a backward notification toward the packet's source. These requests are rate-limited per VC by a programmable hold-off. On a programmable period it emits a status pulse carrying a bitmap of congested VCs, which is sent to the upstream neighbour. A saturating counter tallies perishable drops.

Top module: `vc_cong_monitor`

## Requirements
- R1: Each VC v keeps an average A_v (QW+3 bits, value = A_v/8) that is cleared by reset and updated on every clock edge as A_v <= A_v + floor((8*q_v - A_v)/8), where q_v is the VC's occupancy on `q_occ[v*QW +: QW]` at that edge.
- R2: VC v is congested while floor(A_v/8) >= `thresh`; each VC is judged only from its own occupancy.
- R3: `pkt_fecn_out` equals `pkt_fecn_in` OR (`pkt_valid` AND the VC selected by `pkt_vc` is congested), in the same cycle; an incoming set flag is never cleared.
- R4: A valid packet on a congested VC that is not dropped and whose VC is not in hold-off makes `bn_req` high for exactly the following cycle, with `bn_vc` equal to that packet's VC.
- R5: After a notification for VC v, packets on v raise no further notification during the next `bn_gap` cycles; notifications for other VCs are not held back.
- R6: `pkt_drop` is high in the same cycle exactly when `pkt_valid`, `pkt_perish` and the selected VC's occupancy is all ones (2^QW-1); a packet without the perishable flag is never dropped.
- R7: `drop_cnt` is cleared by reset, rises by one for every dropped packet and holds at all ones.
- R8: `rpt_valid` is a one-cycle pulse every `rpt_period`+1 cycles; with the report counter at or above `rpt_period` at an edge, the next cycle shows the pulse and `rpt_map` bit v holds VC v's congestion state from before that edge.
- R9: During and right after reset, `bn_req`, `rpt_valid`, `rpt_map` and `drop_cnt` are zero and no VC is congested for a nonzero threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_occ | input | NUM_VC*QW | Per-VC queue occupancy, VC v in bits v*QW +: QW |
| thresh | input | QW | Congestion threshold on the integer average |
| bn_gap | input | IW | Per-VC hold-off cycles after a backward notification |
| rpt_period | input | IW | Status report period minus one |
| pkt_valid | input | 1 | A packet header is present |
| pkt_vc | input | VCW | VC of the present packet |
| pkt_fecn_in | input | 1 | Forward-congestion flag as received |
| pkt_perish | input | 1 | Source allows this packet to be dropped |
| pkt_fecn_out | output | 1 | Forward-congestion flag to send on |
| pkt_drop | output | 1 | Discard the present packet |
| bn_req | output | 1 | Request a backward notification |
| bn_vc | output | VCW | VC of the requested notification |
| rpt_valid | output | 1 | Status report pulse |
| rpt_map | output | NUM_VC | Congested-VC bitmap of the report |
| drop_cnt | output | DW | Saturating count of drops |

## Verification
The bench sweeps the threshold across occupancies near the average's settling point, where a comparison with the wrong direction or against the fractional average would flip the forward flag one level off. It sweeps the hold-off and report period from zero upward, where an off-by-one counter would issue a notification or report a cycle early or late. It runs a perishable stream into a full queue past the counter's limit, where a wrapping counter would read back zero. Occupancy one below full and non-perishable packets on a full queue confirm that nothing else is dropped.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  // fractional bits of the running average (weight 1/8)
  localparam int unsigned AVG_FRAC = 3;
endpackage

// File: rtl/vcm_ewma.sv
module vcm_ewma #(
  parameter int unsigned QW   = 5,
  parameter int unsigned FRAC = vcm_pkg::AVG_FRAC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [QW-1:0] occ,
  output logic [QW-1:0] avg_int
);
  localparam int unsigned AW = QW + FRAC;

  logic [AW-1:0]        avg_q;
  logic [AW-1:0]        avg_d;
  logic signed [AW+1:0] diff;
  logic signed [AW+1:0] sum;

  always_comb begin
    diff  = $signed({2'b00, occ, {FRAC{1'b0}}}) - $signed({2'b00, avg_q});
    sum   = $signed({2'b00, avg_q}) + (diff >>> FRAC);
    avg_d = sum[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) avg_q <= '0;
    else        avg_q <= avg_d;
  end

  assign avg_int = avg_q[AW-1:FRAC];
endmodule

// File: rtl/vcm_holdoff.sv
module vcm_holdoff #(
  parameter int unsigned IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [IW-1:0] gap,
  output logic          idle
);
  logic [IW-1:0] cnt_q;
  logic [IW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = fire || (cnt_q != '0);
    cnt_d  = fire ? gap : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign idle = (cnt_q == '0);
endmodule

// File: rtl/vcm_report.sv
module vcm_report #(
  parameter int unsigned NUM_VC = 4,
  parameter int unsigned IW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IW-1:0]     period,
  input  logic [NUM_VC-1:0] cong,
  output logic              rpt_valid,
  output logic [NUM_VC-1:0] rpt_map
);
  logic [IW-1:0] cnt_q;
  logic [IW-1:0] cnt_d;
  logic          due;

  always_comb begin
    due   = (cnt_q >= period);
    cnt_d = due ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      rpt_valid <= 1'b0;
      rpt_map   <= '0;
    end else begin
      cnt_q     <= cnt_d;
      rpt_valid <= due;
      if (due) rpt_map <= cong;
    end
  end
endmodule

// File: rtl/vc_cong_monitor.sv
module vc_cong_monitor #(
  parameter int unsigned NUM_VC = 4,
  parameter int unsigned QW     = 5,
  parameter int unsigned IW     = 8,
  parameter int unsigned DW     = 8,
  localparam int unsigned VCW   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_VC*QW-1:0] q_occ,
  input  logic [QW-1:0]        thresh,
  input  logic [IW-1:0]        bn_gap,
  input  logic [IW-1:0]        rpt_period,
  input  logic                 pkt_valid,
  input  logic [VCW-1:0]       pkt_vc,
  input  logic                 pkt_fecn_in,
  input  logic                 pkt_perish,
  output logic                 pkt_fecn_out,
  output logic                 pkt_drop,
  output logic                 bn_req,
  output logic [VCW-1:0]       bn_vc,
  output logic                 rpt_valid,
  output logic [NUM_VC-1:0]    rpt_map,
  output logic [DW-1:0]        drop_cnt
);
  logic [NUM_VC-1:0] cong;
  logic [NUM_VC-1:0] full;
  logic [NUM_VC-1:0] hold_idle;
  logic              bn_fire;
  logic              drop_en;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic [QW-1:0] avg_int;

    vcm_ewma #(.QW(QW)) u_avg (
      .clk     (clk),
      .rst_n   (rst_n),
      .occ     (q_occ[v*QW +: QW]),
      .avg_int (avg_int)
    );

    assign cong[v] = (avg_int >= thresh);
    assign full[v] = (q_occ[v*QW +: QW] == {QW{1'b1}});

    vcm_holdoff #(.IW(IW)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (bn_fire && (pkt_vc == VCW'(v))),
      .gap   (bn_gap),
      .idle  (hold_idle[v])
    );
  end

  always_comb begin
    pkt_drop     = pkt_valid && pkt_perish && full[pkt_vc];
    pkt_fecn_out = pkt_fecn_in || (pkt_valid && cong[pkt_vc]);
    bn_fire      = pkt_valid && cong[pkt_vc] && !pkt_drop && hold_idle[pkt_vc];
    drop_en      = pkt_drop && (drop_cnt != {DW{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bn_req   <= 1'b0;
      bn_vc    <= '0;
      drop_cnt <= '0;
    end else begin
      bn_req <= bn_fire;
      if (bn_fire) bn_vc    <= pkt_vc;
      if (drop_en) drop_cnt <= drop_cnt + 1'b1;
    end
  end

  vcm_report #(.NUM_VC(NUM_VC), .IW(IW)) u_rpt (
    .clk       (clk),
    .rst_n     (rst_n),
    .period    (rpt_period),
    .cong      (cong),
    .rpt_valid (rpt_valid),
    .rpt_map   (rpt_map)
  );
endmodule

// File: rtl/vcm_checker.sv
module vcm_checker #(
  parameter int unsigned NUM_VC = 4,
  parameter int unsigned DW     = 8,
  parameter int unsigned VCW    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pkt_valid,
  input logic              pkt_fecn_in,
  input logic              pkt_perish,
  input logic              pkt_fecn_out,
  input logic              pkt_drop,
  input logic              bn_req,
  input logic              rpt_valid,
  input logic [NUM_VC-1:0] rpt_map,
  input logic [DW-1:0]     drop_cnt
);
  AST_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_fecn_in |-> pkt_fecn_out); // R3
  AST_DROP_NEEDS_PERISH: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_drop |-> (pkt_perish && pkt_valid)); // R6
  AST_NOTICE_AFTER_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_drop |=> !bn_req); // R4
  AST_NOTICE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> !bn_req); // R4
  AST_DROP_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_cnt >= $past(drop_cnt))); // R7
  AST_DROP_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_drop |=> $stable(drop_cnt)); // R7
  AST_MAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rpt_valid |-> $stable(rpt_map)); // R8
endmodule

bind vc_cong_monitor vcm_checker #(.NUM_VC(NUM_VC), .DW(DW), .VCW(VCW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pkt_valid    (pkt_valid),
  .pkt_fecn_in  (pkt_fecn_in),
  .pkt_perish   (pkt_perish),
  .pkt_fecn_out (pkt_fecn_out),
  .pkt_drop     (pkt_drop),
  .bn_req       (bn_req),
  .rpt_valid    (rpt_valid),
  .rpt_map      (rpt_map),
  .drop_cnt     (drop_cnt)
);

// File: tb/tb_vc_cong_monitor.sv
`timescale 1ns/1ps
module tb_vc_cong_monitor;
  localparam int NV = 4;
  localparam int QW = 5;
  localparam int IW = 8;
  localparam int DW = 8;
  localparam int QMAX = (1 << QW) - 1;
  localparam int DMAX = (1 << DW) - 1;

  logic            clk;
  logic            rst_n;
  logic [NV*QW-1:0] q_occ;
  logic [QW-1:0]   thresh;
  logic [IW-1:0]   bn_gap;
  logic [IW-1:0]   rpt_period;
  logic            pkt_valid;
  logic [1:0]      pkt_vc;
  logic            pkt_fecn_in;
  logic            pkt_perish;
  logic            pkt_fecn_out;
  logic            pkt_drop;
  logic            bn_req;
  logic [1:0]      bn_vc;
  logic            rpt_valid;
  logic [NV-1:0]   rpt_map;
  logic [DW-1:0]   drop_cnt;

  int total = 0;
  int bad   = 0;

  // reference state, computed from the requirements
  int m_avg [NV];
  int m_hold[NV];
  int m_rcnt;
  bit m_bn;
  int m_bnvc;
  bit m_rpt;
  logic [NV-1:0] m_map;
  int m_drop;

  vc_cong_monitor #(.NUM_VC(NV), .QW(QW), .IW(IW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .q_occ(q_occ), .thresh(thresh), .bn_gap(bn_gap),
    .rpt_period(rpt_period), .pkt_valid(pkt_valid), .pkt_vc(pkt_vc),
    .pkt_fecn_in(pkt_fecn_in), .pkt_perish(pkt_perish), .pkt_fecn_out(pkt_fecn_out),
    .pkt_drop(pkt_drop), .bn_req(bn_req), .bn_vc(bn_vc), .rpt_valid(rpt_valid),
    .rpt_map(rpt_map), .drop_cnt(drop_cnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int qv(int v);
    return int'(q_occ[v*QW +: QW]);
  endfunction

  function automatic bit m_cong(int v);
    return (m_avg[v] / 8) >= int'(thresh);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < NV; v++) begin m_avg[v] = 0; m_hold[v] = 0; end
      m_rcnt = 0; m_bn = 0; m_bnvc = 0; m_rpt = 0; m_map = '0; m_drop = 0;
    end else begin
      logic [NV-1:0] c_old;
      bit dr, fire;
      int vc, d, inc;
      for (int v = 0; v < NV; v++) c_old[v] = m_cong(v);
      vc   = int'(pkt_vc);
      dr   = pkt_valid && pkt_perish && (qv(vc) == QMAX);
      fire = pkt_valid && c_old[vc] && !dr && (m_hold[vc] == 0);
      m_bn = fire;
      if (fire) m_bnvc = vc;
      for (int v = 0; v < NV; v++) begin
        if (fire && v == vc) m_hold[v] = int'(bn_gap);
        else if (m_hold[v] > 0) m_hold[v] = m_hold[v] - 1;
      end
      if (m_rcnt >= int'(rpt_period)) begin
        m_rpt = 1; m_map = c_old; m_rcnt = 0;
      end else begin
        m_rpt = 0; m_rcnt = m_rcnt + 1;
      end
      if (dr && m_drop < DMAX) m_drop = m_drop + 1;
      for (int v = 0; v < NV; v++) begin
        d = 8 * qv(v) - m_avg[v];
        inc = (d >= 0) ? d / 8 : -((-d + 7) / 8);
        m_avg[v] = m_avg[v] + inc;
      end
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic set_q(input int v, input int val);
    q_occ[v*QW +: QW] = QW'(val);
  endtask

  // one cycle: check registered outputs, drive a packet, check same-cycle outputs
  task automatic step(input bit vld, input int vc, input bit fi, input bit pe);
    int cv;
    @(negedge clk);
    chk("R4 R5 bn_req", int'(bn_req), int'(m_bn));
    if (m_bn) chk("R4 bn_vc", int'(bn_vc), m_bnvc);
    chk("R8 rpt_valid", int'(rpt_valid), int'(m_rpt));
    if (m_rpt) chk("R8 rpt_map", int'(rpt_map), int'(m_map));
    chk("R7 drop_cnt", int'(drop_cnt), m_drop);
    pkt_valid = vld; pkt_vc = 2'(vc); pkt_fecn_in = fi; pkt_perish = pe;
    #1;
    cv = vld ? int'(m_cong(vc)) : 0;
    chk("R1 R2 R3 fecn", int'(pkt_fecn_out), int'(fi) | cv);
    chk("R6 drop", int'(pkt_drop), int'(vld && pe && qv(vc) == QMAX));
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; q_occ = '0; thresh = 5'd4; bn_gap = 8'd3; rpt_period = 8'd5;
    pkt_valid = 0; pkt_vc = 0; pkt_fecn_in = 0; pkt_perish = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 bn_req", int'(bn_req), 0);
    chk("R9 rpt_valid", int'(rpt_valid), 0);
    chk("R9 rpt_map", int'(rpt_map), 0);
    chk("R9 drop_cnt", int'(drop_cnt), 0);
    pkt_valid = 1; pkt_vc = 0; #1;
    chk("R9 fecn", int'(pkt_fecn_out), 0);
    pkt_valid = 0;
    rst_n = 1'b1;

    // ramp one VC, packets rotate over all VCs (R1 R2 independence)
    set_q(0, 20);
    for (int i = 0; i < 40; i++) step(1, i % NV, 0, 0);
    set_q(1, 7); set_q(2, QMAX); set_q(3, 12);
    for (int i = 0; i < 40; i++) step(1, (i * 3) % NV, i % 5 == 0, 0);

    // threshold sweep around settled averages
    for (int t = 0; t <= QMAX; t++) begin
      thresh = 5'(t);
      for (int i = 0; i < 4; i++) step(1, i, 0, 0);
    end

    // falling occupancy
    thresh = 5'd6;
    set_q(0, 0); set_q(2, 3);
    for (int i = 0; i < 40; i++) step(1, i % NV, 0, 0);

    // hold-off sweep on a congested VC, interleaved with another VC
    set_q(0, 25); set_q(3, 25); thresh = 5'd10;
    for (int i = 0; i < 30; i++) step(0, 0, 0, 0);
    for (int g = 0; g <= 6; g++) begin
      bn_gap = 8'(g);
      for (int i = 0; i < 16; i++) step(1, 0, 0, 0);
      for (int i = 0; i < 12; i++) step(1, (i % 2) ? 3 : 0, 0, 0);
      for (int i = 0; i < 8; i++) step(i % 3 == 0, 0, 0, 0);
    end

    // report period sweep
    for (int p = 0; p <= 6; p++) begin
      rpt_period = 8'(p);
      for (int i = 0; i < 20; i++) step(i % 2, i % NV, 0, 0);
    end

    // perishable handling: full, one below full, non-perishable on full
    set_q(1, QMAX); set_q(2, QMAX - 1);
    for (int i = 0; i < 30; i++) step(0, 0, 0, 0);
    for (int i = 0; i < 16; i++) step(1, i % NV, 0, 1);
    for (int i = 0; i < 16; i++) step(1, 1, 0, 0);
    // saturation of the drop counter
    for (int i = 0; i < 300; i++) step(1, 1, i % 2, 1);
    for (int i = 0; i < 8; i++) step(1, 1, 0, 1);

    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule